// File: doc/BRIEF.md
# Serial Real-Time Clock Register Bank

This block is the register side of a real-time clock that sits behind a byte-oriented serial target port. It owns a 64-byte address space: seven BCD timekeeping registers at addresses 0 to 6, a control byte at address 7 and general-purpose storage in the remaining bytes. The bit-level serial protocol is handled elsewhere. This block only sees whole bytes: a start pulse marks a new transaction, a write strobe carries a byte from the host, and a read strobe asks for the byte at the current pointer.

After a start, the first byte the host writes becomes the register pointer. Every later byte that is read or written uses the pointer and then moves it on by one. A once-per-second tick input advances the calendar: seconds, minutes, hours (in either a 24-hour or a 12-hour AM/PM encoding that software picks in the hours byte), a free-running day-of-week counter, date, month and a two-digit year with leap Februaries.

Top module: `rtc_regbank`

## Requirements
- R1: After reset all 64 bytes read as zero, the pointer is 0 (a read with no preceding start returns address 0), and the clock runs, so the first tick makes seconds read 0x01.
- R2: The first byte written on or after a `xfer_start` pulse (a write in the same cycle as the start counts) loads the pointer from its low 6 bits. Each later written or read byte uses the pointer and then increments it by one.
- R3: The pointer wraps from 63 to 0.
- R4: A read strobe returns on `rd_data` in the next cycle the byte stored at the pointer.
- R5: Bit 7 of the seconds byte (address 0) halts the clock: while it is 1, ticks change no time register. While it is 0, each tick adds one second in BCD.
- R6: Seconds roll from 0x59 to 0x00 and carry into minutes; minutes roll from 0x59 to 0x00 and carry into hours.
- R7: With hours bit 6 clear (24-hour encoding, BCD 00 to 23), hour 0x23 rolls to 0x00 and starts a new day.
- R8: With hours bit 6 set (12-hour encoding, bit 5 = PM, BCD 1 to 12 in bits 4:0), 11 AM (0x51) goes to 12 PM (0x72) with no new day, 12 PM (0x72) goes to 1 PM (0x61), 11 PM (0x71) goes to 12 AM (0x52) and starts a new day, and 12 AM (0x52) goes to 1 AM (0x41).
- R9: Day of week (address 3) counts 1 to 7 on each new day and returns from 7 to 1, independently of the date.
- R10: Date (address 4) returns to 0x01 after the last day of the month and carries into the month (address 5, BCD 1 to 12). April, June, September and November have 30 days. February has 29 days when the year (address 6) is divisible by 4 and 28 days otherwise. The other months have 31 days. Month 0x12 rolls to 0x01 and carries into the year, and year 0x99 rolls to 0x00.
- R11: A write to the control byte (address 7) stores bits 2, 3 and 6 as zero. Bit 5 (oscillator-stop flag) can be cleared by writing 0 but never set by writing 1. The byte 0xFF therefore reads back as 0x93 from the reset state.
- R12: Addresses 8 to 63 store any written byte unchanged.
- R13: A tick that arrives in the same cycle as a data-byte write is dropped, and the time registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start-of-transaction pulse; the next written byte is an address |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Byte written by the host |
| rd_req | input | 1 | Host byte read strobe (ignored when `wr_valid` is high) |
| rd_data | output | 8 | Byte at the pointer, registered on a read strobe |
| sec_tick | input | 1 | One-second tick, one cycle wide |

## Verification
The hardest cases to reach are the far ends of the carry chain: a single tick that ripples from seconds through the year, the leap-February boundary, and the four 12-hour transitions around noon and midnight. Each of these needs a full calendar state that only host writes can set up. The bench loads a whole time image through one transaction (address byte 0 followed by seven data bytes), issues exactly one tick, and reads all seven bytes back from address 0. Dropped ticks are produced by raising the tick and a RAM write strobe in the same cycle.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  // one-step BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    logic [6:0] tens;
    tens = b / 7'd10;
    return {tens[3:0], 4'(b - tens * 7'd10)};
  endfunction

  // hours byte -> 0..23
  function automatic logic [6:0] hour_to_24(input logic [7:0] h);
    logic [6:0] t;
    if (h[6]) begin
      t = bcd2bin({3'b000, h[4:0]});
      if (t == 7'd12) t = 7'd0;
      if (h[5]) t = t + 7'd12;
    end else begin
      t = bcd2bin({2'b00, h[5:0]});
    end
    return t;
  endfunction

  // 0..23 -> hours byte in the chosen encoding
  function automatic logic [7:0] hour_encode(input logic mode12, input logic [6:0] h24);
    logic [6:0] t;
    logic [7:0] b;
    if (!mode12) return bin2bcd(h24);
    t = (h24 >= 7'd12) ? h24 - 7'd12 : h24;
    if (t == 7'd0) t = 7'd12;
    b = bin2bcd(t);
    return {1'b0, 1'b1, (h24 >= 7'd12), b[4:0]};
  endfunction

  // last valid date of a month, as BCD
  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] m;
    logic [6:0] y;
    m = bcd2bin(mon);
    y = bcd2bin(yr);
    if (m == 7'd2)                             return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
    if (m == 7'd4 || m == 7'd6 || m == 7'd9 || m == 7'd11) return 8'h30;
    return 8'h31;
  endfunction

  // control byte write: reserved bits cleared, stop flag clear-only
  function automatic logic [7:0] ctrl_merge(input logic [7:0] nw, input logic [7:0] old);
    logic [7:0] keep;
    keep = 8'hB3 & ~8'h20;
    return (nw & keep) | (nw & old & 8'h20);
  endfunction

endpackage

// File: rtl/rtc_ptr.sv
`timescale 1ns/1ps
module rtc_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  output logic [ADDR_W-1:0] ptr,
  output logic              addr_wr,
  output logic              data_wr,
  output logic              rd_go
);
  logic addr_pending;
  logic addr_now;

  assign addr_now = xfer_start | addr_pending;
  assign addr_wr  = wr_valid & addr_now;
  assign data_wr  = wr_valid & ~addr_now;
  assign rd_go    = rd_req & ~wr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr          <= '0;
      addr_pending <= 1'b0;
    end else begin
      if (addr_wr) begin
        ptr          <= wr_data[ADDR_W-1:0];
        addr_pending <= 1'b0;
      end else begin
        if (xfer_start) addr_pending <= 1'b1;
        if (data_wr || rd_go) ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_time_adv.sv
`timescale 1ns/1ps
module rtc_time_adv
  import rtc_pkg::*;
(
  input  logic [7:0] sec,
  input  logic [7:0] min,
  input  logic [7:0] hr,
  input  logic [7:0] wday,
  input  logic [7:0] date,
  input  logic [7:0] mon,
  input  logic [7:0] yr,
  output logic [7:0] n_sec,
  output logic [7:0] n_min,
  output logic [7:0] n_hr,
  output logic [7:0] n_wday,
  output logic [7:0] n_date,
  output logic [7:0] n_mon,
  output logic [7:0] n_yr,
  output logic       day_carry
);
  logic       sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap;
  logic       hr_carry, mon_carry, yr_carry;
  logic [6:0] h24;

  always_comb begin
    h24       = hour_to_24(hr);
    sec_wrap  = sec[6:0] >= 7'h59;
    min_wrap  = min >= 8'h59;
    hr_wrap   = h24 >= 7'd23;
    date_wrap = date >= month_days(mon, yr);
    mon_wrap  = mon >= 8'h12;

    hr_carry  = sec_wrap & min_wrap;
    day_carry = hr_carry & hr_wrap;
    mon_carry = day_carry & date_wrap;
    yr_carry  = mon_carry & mon_wrap;

    n_sec  = sec_wrap ? 8'h00 : bcd_inc({1'b0, sec[6:0]});
    n_min  = !sec_wrap ? min : (min_wrap ? 8'h00 : bcd_inc(min));
    n_hr   = !hr_carry ? hr : hour_encode(hr[6], hr_wrap ? 7'd0 : h24 + 7'd1);
    n_wday = !day_carry ? wday : ((wday >= 8'd7 || wday == 8'd0) ? 8'd1 : wday + 8'd1);
    n_date = !day_carry ? date : (date_wrap ? 8'h01 : bcd_inc(date));
    n_mon  = !mon_carry ? mon : (mon_wrap ? 8'h01 : bcd_inc(mon));
    n_yr   = !yr_carry ? yr : ((yr >= 8'h99) ? 8'h00 : bcd_inc(yr));
  end
endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CTRL_ADDR = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_start,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       rd_req,
  output logic [7:0] rd_data,
  input  logic       sec_tick
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int TIME_REGS = 7;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic              addr_wr, data_wr, rd_go;
  logic              tick_go;
  logic              day_carry;
  logic [7:0]        nxt [TIME_REGS];
  logic [7:0]        sec_q, ctl_q;

  assign sec_q   = mem[0];
  assign ctl_q   = mem[CTRL_ADDR];
  assign tick_go = sec_tick & ~sec_q[7] & ~data_wr;

  rtc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .ptr(ptr), .addr_wr(addr_wr), .data_wr(data_wr), .rd_go(rd_go)
  );

  rtc_time_adv u_adv (
    .sec(mem[0]), .min(mem[1]), .hr(mem[2]), .wday(mem[3]),
    .date(mem[4]), .mon(mem[5]), .yr(mem[6]),
    .n_sec(nxt[0]), .n_min(nxt[1]), .n_hr(nxt[2]), .n_wday(nxt[3]),
    .n_date(nxt[4]), .n_mon(nxt[5]), .n_yr(nxt[6]),
    .day_carry(day_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (data_wr) begin
      if (int'(ptr) == CTRL_ADDR) mem[ptr] <= ctrl_merge(wr_data, mem[ptr]);
      else                        mem[ptr] <= wr_data;
    end else if (tick_go) begin
      for (int i = 0; i < TIME_REGS; i++) mem[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_go) rd_data <= mem[ptr];
  end
endmodule

// File: rtl/rtc_regbank_chk.sv
`timescale 1ns/1ps
module rtc_regbank_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_wr,
  input logic              data_wr,
  input logic              rd_go,
  input logic              tick_go,
  input logic              sec_tick,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] ptr,
  input logic [7:0]        sec_q,
  input logic [7:0]        ctl_q
);
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ptr == $past(wr_data[ADDR_W-1:0])); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || data_wr) |=> ptr == $past(ptr) + 1'b1); // R2

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_go || data_wr) && ptr == '1) |=> ptr == '0); // R3

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !data_wr) |=> $stable(sec_q)); // R5

  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    tick_go |=> sec_q != $past(sec_q)); // R5

  AST_TICK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && data_wr) |-> !tick_go); // R13

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & 8'h4C) == 8'h00); // R11

  AST_OSF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[5] |=> !ctl_q[5]); // R11
endmodule

bind rtc_regbank rtc_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
  .rd_go(rd_go), .tick_go(tick_go), .sec_tick(sec_tick), .wr_data(wr_data),
  .ptr(ptr), .sec_q(sec_q), .ctl_q(ctl_q)
);

// File: tb/sim_rtc_regbank.sv
`timescale 1ns/1ps
module sim_rtc_regbank;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       xfer_start = 0;
  logic       wr_valid = 0;
  logic [7:0] wr_data = 0;
  logic       rd_req = 0;
  logic       sec_tick = 0;
  logic [7:0] rd_data;
  int n_run = 0;
  int n_fail = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  rtc_regbank u0 (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .sec_tick(sec_tick)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    @(negedge clk); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
    wr_byte(a);
  endtask

  task automatic rd_byte(output logic [7:0] d);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0; d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
    set_ptr(8'd0);
    wr_byte(s); wr_byte(m); wr_byte(h); wr_byte(w); wr_byte(d); wr_byte(mo); wr_byte(y);
  endtask

  task automatic chk_time(input string req, input logic [7:0] s, m, h, w, d, mo, y);
    set_ptr(8'd0);
    rd_byte(got); chk({req, " sec"}, got, s);
    rd_byte(got); chk({req, " min"}, got, m);
    rd_byte(got); chk({req, " hour"}, got, h);
    rd_byte(got); chk({req, " wday"}, got, w);
    rd_byte(got); chk({req, " date"}, got, d);
    rd_byte(got); chk({req, " month"}, got, mo);
    rd_byte(got); chk({req, " year"}, got, y);
  endtask

  task automatic t_reset();
    chk("R1 rd_data after reset", rd_data, 8'h00);
    tick();
    rd_byte(got); chk("R1 R4 pointer 0, clock runs", got, 8'h01);
    rd_byte(got); chk("R1 R2 next byte zero", got, 8'h00);
    set_ptr(8'd8);
    for (int i = 8; i < 64; i++) begin
      rd_byte(got); chk("R1 RAM zero", got, 8'h00);
    end
  endtask

  task automatic t_start_with_write();
    @(negedge clk); xfer_start = 1; wr_valid = 1; wr_data = 8'd20;
    @(negedge clk); xfer_start = 0; wr_valid = 0;
    wr_byte(8'h3C);
    set_ptr(8'd20); rd_byte(got); chk("R2 start+write is address", got, 8'h3C);
  endtask

  task automatic t_wrap_ram();
    set_ptr(8'd62);
    wr_byte(8'hAA); wr_byte(8'hBB); wr_byte(8'h80);
    set_ptr(8'd62);
    rd_byte(got); chk("R12 RAM 62", got, 8'hAA);
    rd_byte(got); chk("R3 R12 RAM 63", got, 8'hBB);
    rd_byte(got); chk("R3 wrap to 0", got, 8'h80);
    set_ptr(8'd40); wr_byte(8'h00); wr_byte(8'hFF);
    set_ptr(8'd40);
    rd_byte(got); chk("R12 RAM zero byte", got, 8'h00);
    rd_byte(got); chk("R12 RAM all ones", got, 8'hFF);
  endtask

  task automatic t_ctrl();
    set_ptr(8'd7); wr_byte(8'hFF);
    set_ptr(8'd7); rd_byte(got); chk("R11 ctrl FF", got, 8'h93);
    set_ptr(8'd7); wr_byte(8'h20);
    set_ptr(8'd7); rd_byte(got); chk("R11 flag not settable", got, 8'h00);
  endtask

  task automatic t_halt();
    set_time(8'h85, 8'h10, 8'h05, 8'h02, 8'h03, 8'h04, 8'h05);
    tick(); tick();
    chk_time("R5 halted", 8'h85, 8'h10, 8'h05, 8'h02, 8'h03, 8'h04, 8'h05);
    set_time(8'h41, 8'h10, 8'h05, 8'h02, 8'h03, 8'h04, 8'h05);
    tick();
    chk_time("R5 running", 8'h42, 8'h10, 8'h05, 8'h02, 8'h03, 8'h04, 8'h05);
    set_time(8'h59, 8'h41, 8'h05, 8'h02, 8'h03, 8'h04, 8'h05);
    tick();
    chk_time("R6 sec carry", 8'h00, 8'h42, 8'h05, 8'h02, 8'h03, 8'h04, 8'h05);
  endtask

  task automatic t_full_carry();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick();
    chk_time("R6 R7 R9 R10 full carry", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_12h();
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h10, 8'h05, 8'h24);
    tick();
    chk_time("R8 11AM->12PM", 8'h00, 8'h00, 8'h72, 8'h03, 8'h10, 8'h05, 8'h24);
    set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h10, 8'h05, 8'h24);
    tick();
    chk_time("R8 12PM->1PM", 8'h00, 8'h00, 8'h61, 8'h03, 8'h10, 8'h05, 8'h24);
    set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h05, 8'h24);
    tick();
    chk_time("R8 R9 11PM->12AM", 8'h00, 8'h00, 8'h52, 8'h04, 8'h11, 8'h05, 8'h24);
    set_time(8'h59, 8'h59, 8'h52, 8'h04, 8'h11, 8'h05, 8'h24);
    tick();
    chk_time("R8 12AM->1AM", 8'h00, 8'h00, 8'h41, 8'h04, 8'h11, 8'h05, 8'h24);
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h24);
    tick();
    chk_time("R10 R9 leap Feb 28", 8'h00, 8'h00, 8'h00, 8'h06, 8'h29, 8'h02, 8'h24);
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h29, 8'h02, 8'h24);
    tick();
    chk_time("R10 leap Feb 29", 8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h03, 8'h24);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    tick();
    chk_time("R10 plain Feb 28", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    tick();
    chk_time("R10 April 30", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h23);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23);
    tick();
    chk_time("R10 Jan 30", 8'h00, 8'h00, 8'h00, 8'h02, 8'h31, 8'h01, 8'h23);
  endtask

  task automatic t_tick_drop();
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    set_ptr(8'd10);
    @(negedge clk); wr_valid = 1; wr_data = 8'h55; sec_tick = 1;
    @(negedge clk); wr_valid = 0; sec_tick = 0;
    chk_time("R13 tick dropped", 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    set_ptr(8'd10); rd_byte(got); chk("R13 R12 write kept", got, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start_with_write();
    t_wrap_ram();
    t_ctrl();
    t_halt();
    t_full_carry();
    t_12h();
    t_months();
    t_tick_drop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule